// File: doc/BRIEF.md
# Two-Level Carry Lookahead Adder

This block adds two unsigned 16-bit operands and a carry-in. It returns a 16-bit sum and a carry-out. It is purely combinational, so a result is valid in the same cycle the operands are applied. It is meant to sit in a datapath where the carry chain of a plain ripple adder would be too slow.

The operand width is cut into four slices of four bits each. Every slice forms a generate term (AND) and a propagate term (XOR) for each of its bits. From these it computes its internal carries in two-level sum-of-products form, starting from the slice's own carry-in. It also condenses its four bit pairs into one slice-level generate and propagate.

A second lookahead stage takes those four slice-level pairs and the external carry-in. From them it forms the carry entering each slice, plus the final carry-out. No carry therefore travels from one slice to the next. The same lookahead module serves both levels, and the slice width and slice count are parameters.

Top module: `cla_adder16`

## Requirements
- R1: For every input, {carry_out, sum} equals op_a + op_b + carry_in taken as an unsigned 17-bit value.
- R2: The carry delivered by the second stage into slice k equals bit 4k of the unsigned sum of the low 4k bits of both operands plus carry_in. It also matches the carry that slice k-1 produces locally.
- R3: When every bit propagates (op_a XOR op_b is all ones), carry_out equals carry_in. In that case every sum bit equals the inverse of carry_in.
- R4: When bit 15 of both operands is 1, carry_out is 1 whatever the other inputs are.
- R5: All-ones plus one (op_a = 16'hFFFF, op_b = 16'h0001, carry_in = 0) gives sum 16'h0000 and carry_out 1.
- R6: Both operands zero with carry_in = 1 gives sum 16'h0001 and carry_out 0. With carry_in = 0 it gives sum 0 and carry_out 0.
- R7: Swapping op_a and op_b does not change sum or carry_out.
- R8: The outputs have no storage. A new input set is reflected on sum and carry_out before the next clock edge of the surrounding logic.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 16 | First unsigned operand |
| op_b | input | 16 | Second unsigned operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | 16 | Low 16 bits of the total |
| carry_out | output | 1 | Carry out of bit 15 |

## Verification
The hardest case to reach from the ports is a carry that begins in the lowest slice and must pass through every higher slice purely by propagation. In that case only the second-stage equations carry it, and a wrong product term anywhere in them shows up. Random operands almost never make all sixteen propagate terms true at once. The stimulus therefore builds such operands directly: complementary patterns, and a lone generate in one slice with full propagation above it, placed at each slice boundary. Random vectors and operand swaps then cover the mixed cases.

// File: rtl/cla_pkg.sv
package cla_pkg;
   localparam int unsigned CLA_GROUP_W_DEF    = 4;
   localparam int unsigned CLA_NUM_GROUPS_DEF = 4;

   typedef struct packed {
      logic gen;
      logic prop;
   } pg_t;
endpackage

// File: rtl/cla_pg_cell.sv
module cla_pg_cell
   import cla_pkg::*;
(
   input  logic bit_a,
   input  logic bit_b,
   output pg_t  pg
);
   always_comb begin
      pg.gen  = bit_a & bit_b;
      pg.prop = bit_a ^ bit_b;
   end
endmodule

// File: rtl/cla_lookahead.sv
// Generic lookahead: carries into each position in sum-of-products form,
// plus the condensed block generate/propagate. Used at both levels.
module cla_lookahead #(
   parameter int unsigned N = 4
) (
   input  logic [N-1:0] g,
   input  logic [N-1:0] p,
   input  logic         ci,
   output logic [N:0]   c,
   output logic         blk_g,
   output logic         blk_p
);
   initial begin
      if (N < 1) $error("cla_lookahead: N must be at least 1");
   end

   always_comb begin
      c[0] = ci;
      for (int k = 1; k <= N; k++) begin
         logic term;
         logic chain;
         term  = 1'b0;
         chain = ci;
         for (int j = 0; j < k; j++) begin
            logic prod;
            prod = g[j];
            for (int m = j + 1; m < k; m++) prod = prod & p[m];
            term  = term | prod;
            chain = chain & p[j];
         end
         c[k] = term | chain;
      end
   end

   always_comb begin
      blk_g = 1'b0;
      for (int j = 0; j < N; j++) begin
         logic prod;
         prod = g[j];
         for (int m = j + 1; m < N; m++) prod = prod & p[m];
         blk_g = blk_g | prod;
      end
      blk_p = &p;
   end
endmodule

// File: rtl/cla_group.sv
module cla_group
   import cla_pkg::*;
#(
   parameter int unsigned W = 4
) (
   input  logic [W-1:0] ga,
   input  logic [W-1:0] gb,
   input  logic         gci,
   output logic [W-1:0] gsum,
   output logic         grp_g,
   output logic         grp_p,
   output logic         grp_co
);
   pg_t [W-1:0]  pg;
   logic [W-1:0] gv;
   logic [W-1:0] pv;
   logic [W:0]   cv;

   for (genvar i = 0; i < W; i++) begin : g_bit
      cla_pg_cell u_pg (
         .bit_a (ga[i]),
         .bit_b (gb[i]),
         .pg    (pg[i])
      );
      assign gv[i] = pg[i].gen;
      assign pv[i] = pg[i].prop;
   end

   cla_lookahead #(.N(W)) u_la (
      .g     (gv),
      .p     (pv),
      .ci    (gci),
      .c     (cv),
      .blk_g (grp_g),
      .blk_p (grp_p)
   );

   assign gsum   = pv ^ cv[W-1:0];
   assign grp_co = cv[W];
endmodule

// File: rtl/cla_adder16.sv
module cla_adder16
   import cla_pkg::*;
#(
   parameter int unsigned GROUP_W    = CLA_GROUP_W_DEF,
   parameter int unsigned NUM_GROUPS = CLA_NUM_GROUPS_DEF,
   localparam int unsigned WIDTH     = GROUP_W * NUM_GROUPS
) (
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] op_b,
   input  logic             carry_in,
   output logic [WIDTH-1:0] sum,
   output logic             carry_out
);
   initial begin
      if (GROUP_W < 2)    $error("cla_adder16: GROUP_W must be at least 2");
      if (NUM_GROUPS < 2) $error("cla_adder16: NUM_GROUPS must be at least 2");
   end

   logic [NUM_GROUPS-1:0] grp_g;
   logic [NUM_GROUPS-1:0] grp_p;
   logic [NUM_GROUPS-1:0] grp_co;
   logic [NUM_GROUPS:0]   lvl2_c;
   logic [NUM_GROUPS-1:0] grp_cin;
   logic                  top_g;
   logic                  top_p;

   for (genvar k = 0; k < NUM_GROUPS; k++) begin : g_grp
      cla_group #(.W(GROUP_W)) u_grp (
         .ga     (op_a[k*GROUP_W +: GROUP_W]),
         .gb     (op_b[k*GROUP_W +: GROUP_W]),
         .gci    (grp_cin[k]),
         .gsum   (sum[k*GROUP_W +: GROUP_W]),
         .grp_g  (grp_g[k]),
         .grp_p  (grp_p[k]),
         .grp_co (grp_co[k])
      );
   end

   cla_lookahead #(.N(NUM_GROUPS)) u_lvl2 (
      .g     (grp_g),
      .p     (grp_p),
      .ci    (carry_in),
      .c     (lvl2_c),
      .blk_g (top_g),
      .blk_p (top_p)
   );

   assign grp_cin   = lvl2_c[NUM_GROUPS-1:0];
   assign carry_out = lvl2_c[NUM_GROUPS];
endmodule

// File: rtl/cla_adder16_chk.sv
module cla_adder16_chk #(
   parameter int unsigned GROUP_W    = 4,
   parameter int unsigned NUM_GROUPS = 4,
   localparam int unsigned WIDTH     = GROUP_W * NUM_GROUPS
) (
   input logic [WIDTH-1:0]      op_a,
   input logic [WIDTH-1:0]      op_b,
   input logic                  carry_in,
   input logic [WIDTH-1:0]      sum,
   input logic                  carry_out,
   input logic [NUM_GROUPS-1:0] grp_cin,
   input logic [NUM_GROUPS-1:0] grp_co,
   input logic                  top_g,
   input logic                  top_p
);
   logic known;
   assign known = !$isunknown({op_a, op_b, carry_in});

   always_comb begin
      if (known) begin
         // R1
         sum_total_chk: assert ({carry_out, sum} ==
            ({1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in}));
         // R4
         top_gen_chk: assert (!(op_a[WIDTH-1] & op_b[WIDTH-1]) || carry_out);
         // R3
         full_prop_chk: assert (!top_p || (carry_out == carry_in));
         // R4
         blk_gen_chk: assert (!top_g || carry_out);
         // R2
         last_link_chk: assert (grp_co[NUM_GROUPS-1] == carry_out);
      end
   end

   for (genvar k = 1; k < NUM_GROUPS; k++) begin : g_link
      logic [WIDTH:0] part;
      logic [WIDTH:0] msk;
      assign msk  = ({{WIDTH{1'b0}}, 1'b1} << (k * GROUP_W)) - 1'b1;
      assign part = ({1'b0, op_a} & msk) + ({1'b0, op_b} & msk)
                    + {{WIDTH{1'b0}}, carry_in};
      always_comb begin
         if (known) begin
            // R2
            grp_cin_chk: assert (grp_cin[k] == part[k*GROUP_W]);
            // R2
            grp_link_chk: assert (grp_co[k-1] == grp_cin[k]);
         end
      end
   end
endmodule

bind cla_adder16 cla_adder16_chk #(
   .GROUP_W    (GROUP_W),
   .NUM_GROUPS (NUM_GROUPS)
) chk_i (
   .op_a      (op_a),
   .op_b      (op_b),
   .carry_in  (carry_in),
   .sum       (sum),
   .carry_out (carry_out),
   .grp_cin   (grp_cin),
   .grp_co    (grp_co),
   .top_g     (top_g),
   .top_p     (top_p)
);

// File: tb/cla_adder16_tb_top.sv
`timescale 1ns/1ps
module cla_adder16_tb_top;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [15:0] op_a;
   logic [15:0] op_b;
   logic        carry_in;
   logic [15:0] sum;
   logic        carry_out;
   int          n_chk  = 0;
   int          n_fail = 0;
   int          cycles = 0;

   always #10 clk = ~clk;

   cla_adder16 dut_i (
      .op_a      (op_a),
      .op_b      (op_b),
      .carry_in  (carry_in),
      .sum       (sum),
      .carry_out (carry_out)
   );

   function automatic logic [16:0] ripple_ref(input logic [15:0] a,
                                              input logic [15:0] b,
                                              input logic ci);
      logic c;
      logic [15:0] s;
      c = ci;
      for (int i = 0; i < 16; i++) begin
         s[i] = a[i] ^ b[i] ^ c;
         c    = (a[i] & b[i]) | (c & (a[i] ^ b[i]));
      end
      return {c, s};
   endfunction

   task automatic check(input string req, input logic [16:0] got,
                        input logic [16:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s a=%h b=%h ci=%b actual=%h expected=%h",
                  req, op_a, op_b, carry_in, got, exp);
      end
   endtask

   task automatic apply(input logic [15:0] a, input logic [15:0] b,
                        input logic ci);
      @(negedge clk);
      op_a = a; op_b = b; carry_in = ci;
      #5;
   endtask

   task automatic add_chk(input string req, input logic [15:0] a,
                          input logic [15:0] b, input logic ci);
      apply(a, b, ci);
      check(req, {carry_out, sum}, ripple_ref(a, b, ci));
   endtask

   task automatic t_reset_state;
      apply(16'h0000, 16'h0000, 1'b0);
      check("R6", {carry_out, sum}, 17'h00000);
      rst = 1'b0;
   endtask

   task automatic t_corners;
      apply(16'hFFFF, 16'h0001, 1'b0);
      check("R5", {carry_out, sum}, 17'h10000);
      apply(16'h0001, 16'hFFFF, 1'b0);
      check("R7", {carry_out, sum}, 17'h10000);
      apply(16'h0000, 16'h0000, 1'b1);
      check("R6", {carry_out, sum}, 17'h00001);
      apply(16'hFFFF, 16'hFFFF, 1'b1);
      check("R1", {carry_out, sum}, 17'h1FFFF);
   endtask

   task automatic t_full_propagate;
      for (int ci = 0; ci < 2; ci++) begin
         apply(16'hAAAA, 16'h5555, ci[0]);
         check("R3", {carry_out, sum}, {ci[0], {16{~ci[0]}}});
         apply(16'hFFFF, 16'h0000, ci[0]);
         check("R3", {carry_out, sum}, {ci[0], {16{~ci[0]}}});
      end
   endtask

   task automatic t_top_generate;
      apply(16'h8000, 16'h8000, 1'b0);
      check("R4", {16'h0000, carry_out}, 17'h00001);
      apply(16'hC3A1, 16'h8F0E, 1'b1);
      check("R4", {16'h0000, carry_out}, 17'h00001);
   endtask

   task automatic t_group_boundaries;
      for (int k = 0; k < 4; k++) begin
         logic [15:0] gen_bit;
         logic [15:0] above;
         gen_bit = 16'h0001 << (4 * k);
         above   = ~((gen_bit << 1) - 16'h0001);
         // lone generate in slice k, full propagation above it
         add_chk("R2", gen_bit | above, gen_bit, 1'b0);
         add_chk("R2", (16'hFFFF >> (4 * k)), 16'h0001 << (4 * k), 1'b0);
         add_chk("R2", (16'h000F << (4 * k)), 16'h0000, 1'b1);
      end
      apply(16'hFFFE, 16'h0001, 1'b1);
      check("R2", {carry_out, sum}, 17'h10000);
   endtask

   task automatic t_random;
      for (int i = 0; i < 400; i++) begin
         logic [15:0] a;
         logic [15:0] b;
         logic        ci;
         logic [16:0] first;
         a  = 16'($urandom);
         b  = 16'($urandom);
         ci = 1'($urandom);
         add_chk("R1", a, b, ci);
         first = {carry_out, sum};
         apply(b, a, ci);
         check("R7", {carry_out, sum}, first);
      end
   endtask

   task automatic t_same_cycle;
      apply(16'h1234, 16'h4321, 1'b0);
      check("R8", {carry_out, sum}, 17'h05555);
      @(negedge clk);
      op_a = 16'hF000; op_b = 16'h1000; carry_in = 1'b0;
      #1;
      check("R8", {carry_out, sum}, 17'h10000);
   endtask

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles == 150000) begin
         n_fail++;
         n_chk++;
         $display("FAIL watchdog actual=%0d expected<150000", cycles);
         $display("End of test - %0d assertions evaluated, %0d failures",
                  n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      op_a = '0; op_b = '0; carry_in = 1'b0;
      repeat (2) @(posedge clk);
      t_reset_state();
      t_corners();
      t_full_propagate();
      t_top_generate();
      t_group_boundaries();
      t_same_cycle();
      t_random();
      $display("End of test - %0d assertions evaluated, %0d failures",
               n_chk, n_fail);
      $finish;
   end
endmodule